// File: doc/BRIEF.md
# TDM Transmit Slot Serializer

This block drives the serial data line of a time-division-multiplexed audio bus. It takes one parallel sample word for each sense channel (current sense and voltage sense in the default build), and it shifts each word out MSB first into a programmable time slot of every frame. The position of each slot is counted in bit-clock periods from the frame-sync edge. The block runs on a fast system clock, `clk`. It samples the bit clock and the frame sync as synchronous levels and acts on the bit-clock edges it detects. A small write-only register port sets the frame geometry and the drive behaviour.

Each bit position is driven, filled or released. A position that no enabled channel owns is either driven low or released to high impedance. The last bit of a word can be driven for a full bit period or only up to the mid-bit edge. An optional keeper phase can follow the word, during which the line is released and the pad keeper holds its level. Output enable (`oe_o`) models the tri-state buffer, and `keep_o` tells the pad that the keeper phase is active.

Sample words arrive through a valid/ready port. `smp_ready` pulses for one `clk` cycle at each frame start. A transfer happens only when `smp_valid` is high in that cycle. The source must hold `smp_data` and `smp_valid` up to the frame start. Nothing stalls if the source is not ready: the words from the previous transfer are sent again. A captured word stays fixed for the whole frame.

Top module: `tdm_tx_serializer`

## Requirements
- R1: After reset all outputs are low, and the configuration is: launch on the falling bit-clock edge, high-impedance fill, frame offset 1, LSB driven for the full period, keeper off, channel 0 slot 0, channel 1 slot 2, both channels disabled.
- R2: Outputs change only on a detected launch edge or on the mid-bit (opposite) edge. Format bit 0 selects the launch edge: 0 for rising, 1 for falling.
- R3: A launch edge at which frame sync is high, after a launch edge at which it was low, is bit position 0. An enabled channel with slot N sends its 16-bit word MSB first over positions offset + 16·N up to offset + 16·N + 15. The offset is format bits 4:2.
- R4: At a launch edge on a position that no enabled channel owns, with no keeper phase active, the line is driven low if format bit 1 is 0 and released (`oe_o` low) if it is 1.
- R5: With the keeper off, format bit 5 = 0 drives the LSB for the full bit period. Format bit 5 = 1 releases the line at the mid-bit edge of the LSB.
- R6: With the keeper on (format bit 6 = 1) and keeper mode 0 (format bit 7 = 0), the line is released at the LSB mid-bit edge and `keep_o` is high for exactly one bit period, up to the next mid-bit edge. The line stays released until the next launch edge, where fill applies.
- R7: With the keeper on and mode 1, `keep_o` stays high and the line stays released from the LSB mid-bit edge until a channel next drives a bit.
- R8: When two enabled channels own the same position, the lower-numbered channel drives the line and `conflict_o` goes high. It stays high until reset.
- R9: `smp_ready` is high for one `clk` cycle at each frame start. Words are taken only when `smp_valid` is also high. Otherwise the previous words are sent again. Changes to `smp_data` after the frame start do not affect the frame.
- R10: A disabled channel never drives its slot positions, so they are filled as in R4.
- R11: Register writes (`cfg_we`) go to address 0 for format, address 1+i for the slot of channel i (bits 5:0), and address 3 for the enables (bit i for channel i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least twice the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, sampled as a level |
| fsync | input | 1 | Frame sync, sampled at launch edges |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| smp_data | input | 32 | Sample words, channel i at bits 16i+15:16i |
| smp_valid | input | 1 | Sample words are valid |
| smp_ready | output | 1 | Frame-start capture pulse |
| sd_o | output | 1 | Serial data |
| oe_o | output | 1 | Serial data drive enable |
| keep_o | output | 1 | Keeper phase active |
| conflict_o | output | 1 | Sticky slot-overlap flag |

## Verification
A bit counter that is off by one shifts every word by one position. That shows at the first owned bit of the next frame, one bit-clock period after the sof edge plus the offset, as a wrong `sd_o` or a wrong `oe_o` at a slot boundary. A stale LSB or keeper state shows within one half bit period as `oe_o` or `keep_o` at the wrong level at the mid-bit edge. A lost capture shows as old data in the first slot of the frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int FMT_OFF_W = 3;

  typedef struct packed {
    logic                 keep_hold;
    logic                 keep_en;
    logic                 lsb_half;
    logic [FMT_OFF_W-1:0] offset;
    logic                 fill_hiz;
    logic                 launch_fall;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{keep_hold: 1'b0, keep_en: 1'b0, lsb_half: 1'b0,
                                 offset: 3'd1, fill_hiz: 1'b1, launch_fall: 1'b1};
endpackage

// File: rtl/tdm_tx_cfg.sv
module tdm_tx_cfg
  import tdm_tx_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SLOT_W = 6,
  parameter int ADDR_W = 3,
  parameter logic [NCH*SLOT_W-1:0] SLOT_RST = 12'h080
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output fmt_t                  fmt,
  output logic [NCH*SLOT_W-1:0] slots,
  output logic [NCH-1:0]        en
);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NCH + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt <= FMT_RESET;
      en  <= '0;
    end else if (we) begin
      if (addr == '0) fmt <= fmt_t'(wdata);
      if (addr == EN_ADDR) en <= wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [SLOT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) slot_q <= SLOT_RST[i*SLOT_W +: SLOT_W];
      else if (we && addr == ADDR_W'(i + 1)) slot_q <= wdata[SLOT_W-1:0];
    end
    assign slots[i*SLOT_W +: SLOT_W] = slot_q;
  end
endmodule

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             launch_fall,
  output logic             launch,
  output logic             half,
  output logic             sof,
  output logic [POS_W-1:0] pos_now
);
  logic             bclk_q;
  logic             fs_q;
  logic [POS_W-1:0] pos_q;
  logic             rise, fall;

  always_ff @(posedge clk) bclk_q <= bclk;

  assign rise   = bclk & ~bclk_q;
  assign fall   = ~bclk & bclk_q;
  assign launch = launch_fall ? fall : rise;
  assign half   = launch_fall ? rise : fall;
  assign sof    = launch & fsync & ~fs_q;

  always_comb begin
    if (sof) pos_now = '0;
    else if (pos_q == '1) pos_now = pos_q;
    else pos_now = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= 1'b0;
      pos_q <= '1;
    end else if (launch) begin
      fs_q  <= fsync;
      pos_q <= pos_now;
    end
  end

  p_pos_zero_after_sof_r3: assert property (@(posedge clk) disable iff (rst)
    sof |=> pos_q == '0);
endmodule

// File: rtl/tdm_tx_slot_sel.sv
module tdm_tx_slot_sel #(
  parameter int NCH = 2,
  parameter int WORD_W = 16,
  parameter int SLOT_W = 6,
  parameter int OFF_W = 3,
  parameter int POS_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [POS_W-1:0]      pos,
  input  logic [OFF_W-1:0]      offset,
  input  logic [NCH*SLOT_W-1:0] slots,
  input  logic [NCH-1:0]        en,
  input  logic [NCH*WORD_W-1:0] words,
  output logic                  any_own,
  output logic                  bit_o,
  output logic                  lsb_o,
  output logic                  multi
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [NCH-1:0] own, bits, lsbs, win;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [POS_W-1:0]  start, rel;
    logic [WORD_W-1:0] w;
    logic [IDX_W-1:0]  idx;
    assign start   = POS_W'(offset) + POS_W'(slots[i*SLOT_W +: SLOT_W]) * POS_W'(WORD_W);
    assign rel     = pos - start;
    assign own[i]  = en[i] && (pos >= start) && (rel < POS_W'(WORD_W));
    assign w       = words[i*WORD_W +: WORD_W];
    assign idx     = IDX_W'(WORD_W - 1) - rel[IDX_W-1:0];
    assign bits[i] = w[idx];
    assign lsbs[i] = (rel == POS_W'(WORD_W - 1));
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (own[i]) win = NCH'(1) << i;
    end
  end

  assign any_own = |own;
  assign bit_o   = |(win & bits);
  assign lsb_o   = |(win & lsbs);
  assign multi   = $countones(own) > 1;

  p_winner_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win) && ((win & ~own) == '0));
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    own[0] |-> win[0]);
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NCH = 2,
  parameter int SLOT_W = 6,
  parameter int ADDR_W = 3,
  parameter logic [NCH*SLOT_W-1:0] SLOT_RST = 12'h080
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bclk,
  input  logic                  fsync,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic [NCH*WORD_W-1:0] smp_data,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  output logic                  sd_o,
  output logic                  oe_o,
  output logic                  keep_o,
  output logic                  conflict_o
);
  localparam int POS_W = $clog2((2 ** FMT_OFF_W) + WORD_W * (2 ** SLOT_W)) + 1;

  fmt_t                  fmt;
  logic [NCH*SLOT_W-1:0] slots;
  logic [NCH-1:0]        en;
  logic                  launch, half, sof;
  logic [POS_W-1:0]      pos_now;
  logic [NCH*WORD_W-1:0] word_q, word_now;
  logic                  any_own, sel_bit, sel_lsb, sel_multi;
  logic                  sd_q, oe_q, keep_q, lsb_q, conflict_q;

  tdm_tx_cfg #(.NCH(NCH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .SLOT_RST(SLOT_RST)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fmt(fmt), .slots(slots), .en(en)
  );

  tdm_tx_timing #(.POS_W(POS_W)) u_timing (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .launch_fall(fmt.launch_fall),
    .launch(launch), .half(half), .sof(sof), .pos_now(pos_now)
  );

  // sample words: one transfer per frame start
  assign smp_ready = sof;
  assign word_now  = (sof && smp_valid) ? smp_data : word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (sof && smp_valid) word_q <= smp_data;
  end

  tdm_tx_slot_sel #(.NCH(NCH), .WORD_W(WORD_W), .SLOT_W(SLOT_W), .OFF_W(FMT_OFF_W),
                    .POS_W(POS_W)) u_sel (
    .clk(clk), .rst(rst), .pos(pos_now), .offset(fmt.offset), .slots(slots), .en(en),
    .words(word_now), .any_own(any_own), .bit_o(sel_bit), .lsb_o(sel_lsb), .multi(sel_multi)
  );

  // line drive: launch edge selects data/fill, mid-bit edge handles LSB release
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q       <= 1'b0;
      oe_q       <= 1'b0;
      keep_q     <= 1'b0;
      lsb_q      <= 1'b0;
      conflict_q <= 1'b0;
    end else if (launch) begin
      if (sel_multi) conflict_q <= 1'b1;
      if (any_own) begin
        sd_q   <= sel_bit;
        oe_q   <= 1'b1;
        keep_q <= 1'b0;
        lsb_q  <= sel_lsb;
      end else begin
        lsb_q <= 1'b0;
        if (keep_q && fmt.keep_en) begin
          oe_q <= 1'b0;
        end else begin
          oe_q   <= ~fmt.fill_hiz;
          sd_q   <= 1'b0;
          keep_q <= 1'b0;
        end
      end
    end else if (half) begin
      if (lsb_q && (fmt.lsb_half || fmt.keep_en)) begin
        oe_q   <= 1'b0;
        keep_q <= fmt.keep_en;
      end else if (keep_q && !fmt.keep_hold) begin
        keep_q <= 1'b0;
      end
    end
  end

  assign sd_o       = sd_q;
  assign oe_o       = oe_q;
  assign keep_o     = keep_q;
  assign conflict_o = conflict_q;

  p_oe_moves_on_edges_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> $past(launch || half));
  p_keep_released_r6: assert property (@(posedge clk) disable iff (rst)
    keep_q |-> !oe_q);
  p_conflict_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    conflict_q |=> conflict_q);
  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (smp_ready && smp_valid) |=> word_q == $past(smp_data));
endmodule

// File: tb/tb_tdm_tx_serializer.sv
`timescale 1ns/1ps
module tb_tdm_tx_serializer;
  logic        clk = 1'b0, rst = 1'b1, bclk = 1'b0, fsync = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready, sd_o, oe_o, keep_o, conflict_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bit c_fall, c_hiz, c_lh, c_ken, c_khold;
  int c_off;
  int c_slot [2];
  bit c_en [2];

  bit m_keep, m_lsb, m_oe, m_sd, m_conf;
  logic [15:0] m_w [2];

  always #2.5 clk = ~clk;

  tdm_tx_serializer dut (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .sd_o(sd_o), .oe_o(oe_o), .keep_o(keep_o), .conflict_o(conflict_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(bit idle);
    @(negedge clk);
    rst = 1'b1; bclk = idle; fsync = 1'b0; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_keep = 0; m_lsb = 0; m_oe = 0; m_sd = 0; m_conf = 0;
    m_w[0] = '0; m_w[1] = '0;
    // R1 reset configuration values
    c_fall = 1; c_hiz = 1; c_off = 1; c_lh = 0; c_ken = 0; c_khold = 0;
    c_slot[0] = 0; c_slot[1] = 2; c_en[0] = 0; c_en[1] = 0;
  endtask

  task automatic push_cfg();
    wr(3'd0, {c_khold, c_ken, c_lh, 3'(c_off), c_hiz, c_fall});   // R11 format layout
    wr(3'd1, 8'(c_slot[0]));
    wr(3'd2, 8'(c_slot[1]));
    wr(3'd3, {6'b0, c_en[1], c_en[0]});
  endtask

  task automatic model_launch(int p, output string tag);
    int n = 0, ow = -1, r = 0;
    bit dis = 0;
    for (int ch = 0; ch < 2; ch++) begin
      int st = c_off + 16 * c_slot[ch];
      if (p >= st && p < st + 16) begin
        if (c_en[ch]) begin
          n++;
          if (ow < 0) begin ow = ch; r = p - st; end
        end else dis = 1;
      end
    end
    if (n > 1) m_conf = 1;
    if (ow >= 0) begin
      m_oe = 1; m_sd = m_w[ow][15 - r]; m_keep = 0; m_lsb = (r == 15);
      tag = (n > 1) ? "R8" : "R3";
    end else begin
      m_lsb = 0;
      if (m_keep && c_ken) begin
        m_oe = 0;
        tag = c_khold ? "R7" : "R6";
      end else begin
        m_oe = !c_hiz; m_sd = 0; m_keep = 0;
        tag = dis ? "R10" : "R4";
      end
    end
  endtask

  task automatic model_half(output string tag);
    if (m_lsb && (c_lh || c_ken)) begin
      m_oe = 0; m_keep = c_ken;
      tag = c_ken ? (c_khold ? "R7" : "R6") : "R5";
    end else if (m_keep && !c_khold) begin
      m_keep = 0; tag = "R6";
    end else begin
      tag = m_lsb ? "R5" : "R2";
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, oe_o, m_oe);
    if (m_oe) chk(tag, sd_o, m_sd);
    chk(tag, keep_o, m_keep);
    chk("R8", conflict_o, m_conf);
  endtask

  task automatic run_frame(int npos, bit valid, logic [15:0] a0, logic [15:0] a1);
    bit L = c_fall ? 1'b0 : 1'b1;
    string tag;
    @(negedge clk);
    fsync = 1'b1; smp_data = {a1, a0}; smp_valid = valid;
    for (int p = 0; p < npos; p++) begin
      @(negedge clk);
      bclk = L;
      if (p == 0) begin
        #1;
        chk("R9", smp_ready, 1'b1);
        if (valid) begin m_w[0] = a0; m_w[1] = a1; end
      end
      @(negedge clk);
      if (p == 0) begin
        fsync = 1'b0; smp_valid = 1'b0; smp_data = ~smp_data;   // R9 mid-frame change
        chk("R9", smp_ready, 1'b0);
      end
      model_launch(p, tag);
      check_all(tag);
      @(negedge clk);
      bclk = ~L;
      @(negedge clk);
      model_half(tag);
      check_all(tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k = 0;
    // R1: reset outputs and reset configuration
    do_reset(1'b1);
    @(negedge clk);
    chk("R1", oe_o, 1'b0);
    chk("R1", keep_o, 1'b0);
    chk("R1", conflict_o, 1'b0);
    chk("R1", smp_ready, 1'b0);
    chk("R1", sd_o, 1'b0);
    c_en[1] = 1;
    wr(3'd3, 8'h02);
    run_frame(1 + 32 + 16 + 3, 1'b1, 16'hC3A5, 16'h5AF0);

    // R8: overlapping slots, lower channel wins, flag sticky
    do_reset(1'b0);
    c_fall = 0; c_hiz = 0; c_off = 2; c_slot[0] = 1; c_slot[1] = 1; c_en[0] = 1; c_en[1] = 1;
    push_cfg();
    @(negedge clk);
    chk("R8", conflict_o, 1'b0);
    run_frame(2 + 32 + 3, 1'b1, 16'h9A1E, 16'h0FF0);
    c_slot[1] = 3;
    wr(3'd2, 8'd3);
    run_frame(2 + 64 + 3, 1'b1, 16'h7311, 16'hE00C);

    // sweep: launch edge, fill, LSB mode, keeper mode, offsets, slot spacing
    for (int f = 0; f < 2; f++)
      for (int h = 0; h < 2; h++)
        for (int lh = 0; lh < 2; lh++)
          for (int kc = 0; kc < 3; kc++)
            for (int oi = 0; oi < 3; oi++) begin
              logic [15:0] w0, w1;
              do_reset(bit'(f));
              c_fall = bit'(f); c_hiz = bit'(h); c_lh = bit'(lh);
              c_ken = (kc != 0); c_khold = (kc == 2);
              c_off = (oi == 0) ? 0 : (oi == 1) ? 3 : 7;
              c_slot[0] = k % 3; c_slot[1] = c_slot[0] + 1 + (k % 2);
              c_en[0] = 1; c_en[1] = (k % 5 != 4);
              push_cfg();
              w0 = 16'(16'h1357 * (k + 1)) ^ 16'hA5A5;
              w1 = {w0[6:0], w0[15:7]} ^ 16'h3C0F;
              run_frame(c_off + 16 * (c_slot[1] + 1) + 3, 1'b1, w0, w1);
              run_frame(c_off + 16 * (c_slot[1] + 1) + 3, 1'b0, ~w0, w1 + 16'd1);
              k++;
            end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule